// File: doc/BRIEF.md
# PCI Configuration Address Generator

This block turns a configuration-space request into the two values a host bridge needs to reach a PCI configuration register through a 16 MB local-bus aperture. The request carries a bus number, an 8-bit device/function value (slot in bits 7:3, function in bits 2:0) and an 8-bit register offset. The block returns a 24-bit offset into the aperture and a 16-bit map word for the window that covers it. Another block issues the actual bus cycle.

When the bus number is zero, the block builds a type 0 cycle. The target device is selected by a single one-hot address line. Slots whose select line fits inside the 24-bit aperture offset set an offset bit. Higher slots set an upper address bit in the map word instead. When the bus number is nonzero, the block builds a type 1 cycle, with the bus, device and function fields packed into the offset.

Requests enter on a valid/ready port, and results leave on a valid/ready port through a single registered stage. `req_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is waiting with `rsp_ready` low holds every output field steady, and the block accepts no new request until that result leaves. A request with an impossible slot still produces a result, with the error flag set.

Top module: `pci_cfg_addr_gen`

## Requirements
- R1: For bus 0, rsp_ofs[10:8] holds the function number and rsp_ofs[7:0] holds the register offset.
- R2: For bus 0 with slot 0..12, rsp_ofs bit (slot+11) is the only bit set in rsp_ofs[23:11], and rsp_map[15:4] is zero.
- R3: For bus 0 with slot 13..20, rsp_map bit (slot-5) is the only bit set in rsp_map[15:4], and rsp_ofs[23:11] is zero.
- R4: Every result carries the configuration type code 3'b101 in rsp_map[3:1]. For bus 0, rsp_map[0] is 0, so the low address bits are driven as zero.
- R5: For a nonzero bus, rsp_ofs equals {bus[7:0], devfn[7:0], reg[7:0]}, with the bus in bits 23:16, devfn in bits 15:8 and the register offset in bits 7:0. rsp_err is 0.
- R6: For a nonzero bus, rsp_map is 16'h000B: type 101 in bits 3:1 and bit 0 set, so the low address bits come from the host.
- R7: For bus 0 with slot 21..31, rsp_err is 1, no select bit is set in either rsp_ofs[23:11] or rsp_map[15:4], and the function and register fields follow R1. rsp_err is 0 for every other request.
- R8: While rsp_valid is 1 and rsp_ready is 0, rsp_valid, rsp_ofs, rsp_map and rsp_err stay unchanged on the next cycle, and req_ready is 0.
- R9: rsp_valid is 0 after reset. req_ready equals (!rsp_valid || rsp_ready). A request accepted at a clock edge gives rsp_valid = 1 with its result after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Slot in bits 7:3, function in bits 2:0 |
| req_reg | input | 8 | Configuration register offset |
| rsp_valid | output | 1 | Result present (done strobe when rsp_ready is high) |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_ofs | output | 24 | Offset into the 16 MB configuration aperture |
| rsp_map | output | 16 | Map word for the configuration window |
| rsp_err | output | 1 | Slot cannot be selected on bus 0 |

## Verification
The hardest condition to reach from the ports is the boundary where the type 0 select bit moves from the top of the aperture offset into the map word. Next to it is the edge where the select bit runs off the map word and the request turns into an error. The stimulus reaches both edges by sweeping all 256 device/function values on bus 0, so slots 12/13 and 20/21 each appear with every function number. It also sweeps several nonzero buses whose bit patterns would expose any field misplacement. A separate sequence stalls the output with a second request already waiting, to show that nothing moves until the consumer drains the first result.

// File: rtl/pci_cfg_addr_pkg.sv
package pci_cfg_addr_pkg;
  // Configuration cycle code in map bits 3:1
  localparam logic [2:0] CFG_CYC_CODE = 3'b101;
  // Lowest map bit that carries an upper address bit
  localparam int MAP_ADR_LSB = 4;
  // Width of the function field inside devfn
  localparam int FUNC_W = 3;
  // Width of the slot field inside devfn
  localparam int SLOT_W = 5;

  typedef enum logic { CYC_TYPE0 = 1'b0, CYC_TYPE1 = 1'b1 } cyc_kind_e;
endpackage

// File: rtl/cfg_type0_gen.sv
module cfg_type0_gen
  import pci_cfg_addr_pkg::*;
#(
  parameter int OFS_W    = 24,
  parameter int MAP_W    = 16,
  parameter int REG_W    = 8,
  parameter int MAP_DROP = 16   // aperture address bit carried by map bit 0
) (
  input  logic [FUNC_W+SLOT_W-1:0] devfn,
  input  logic [REG_W-1:0]         reg_off,
  output logic [OFS_W-1:0]         ofs,
  output logic [MAP_W-1:0]         map,
  output logic                     err
);
  localparam int SEL_BASE  = REG_W + FUNC_W;
  localparam int LOW_MAX   = OFS_W - 1 - SEL_BASE;
  localparam int HIGH_MAX  = MAP_W - 1 + MAP_DROP - SEL_BASE;

  logic [SLOT_W-1:0] slot;
  logic [FUNC_W-1:0] func;
  logic [OFS_W-1:0]  ofs_sel;
  logic [MAP_W-1:0]  map_sel;

  assign slot = devfn[FUNC_W+SLOT_W-1:FUNC_W];
  assign func = devfn[FUNC_W-1:0];

  // One comparator per slot that lands in the aperture offset
  generate
    for (genvar b = 0; b < OFS_W; b++) begin : g_ofs_sel
      if (b >= SEL_BASE && b - SEL_BASE <= LOW_MAX) begin : g_on
        assign ofs_sel[b] = (slot == SLOT_W'(b - SEL_BASE));
      end else begin : g_off
        assign ofs_sel[b] = 1'b0;
      end
    end
    // One comparator per slot that spills into the map word
    for (genvar m = 0; m < MAP_W; m++) begin : g_map_sel
      if (m >= MAP_ADR_LSB && m + MAP_DROP - SEL_BASE > LOW_MAX &&
          m + MAP_DROP - SEL_BASE <= HIGH_MAX) begin : g_on
        assign map_sel[m] = (slot == SLOT_W'(m + MAP_DROP - SEL_BASE));
      end else begin : g_off
        assign map_sel[m] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    ofs = ofs_sel;
    ofs[SEL_BASE-1:0] = {func, reg_off};
    map = map_sel;
    map[MAP_ADR_LSB-1:0] = {CFG_CYC_CODE, 1'b0};
    err = (int'(slot) > HIGH_MAX);
  end
endmodule

// File: rtl/cfg_type1_gen.sv
module cfg_type1_gen
  import pci_cfg_addr_pkg::*;
#(
  parameter int OFS_W = 24,
  parameter int MAP_W = 16,
  parameter int BUS_W = 8,
  parameter int REG_W = 8
) (
  input  logic [BUS_W-1:0]         bus,
  input  logic [FUNC_W+SLOT_W-1:0] devfn,
  input  logic [REG_W-1:0]         reg_off,
  output logic [OFS_W-1:0]         ofs,
  output logic [MAP_W-1:0]         map
);
  localparam int FIELD_W = BUS_W + FUNC_W + SLOT_W + REG_W;

  always_comb begin
    ofs = '0;
    ofs[FIELD_W-1:0] = {bus, devfn, reg_off};
    map = '0;
    map[MAP_ADR_LSB-1:0] = {CFG_CYC_CODE, 1'b1};
  end
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage #(
  parameter int W = 41
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_data <= in_data;
    end
  end

  // R8: a stalled result does not move
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen
  import pci_cfg_addr_pkg::*;
#(
  parameter int OFS_W    = 24,
  parameter int MAP_W    = 16,
  parameter int BUS_W    = 8,
  parameter int REG_W    = 8,
  parameter int MAP_DROP = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [BUS_W-1:0]         req_bus,
  input  logic [FUNC_W+SLOT_W-1:0] req_devfn,
  input  logic [REG_W-1:0]         req_reg,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [OFS_W-1:0]         rsp_ofs,
  output logic [MAP_W-1:0]         rsp_map,
  output logic                     rsp_err
);
  localparam int SEL_BASE = REG_W + FUNC_W;
  localparam int PKT_W    = 1 + MAP_W + OFS_W;

  cyc_kind_e        kind;
  logic [OFS_W-1:0] t0_ofs, t1_ofs, sel_ofs;
  logic [MAP_W-1:0] t0_map, t1_map, sel_map;
  logic             t0_err, sel_err;
  logic [PKT_W-1:0] pkt_in, pkt_out;

  cfg_type0_gen #(.OFS_W(OFS_W), .MAP_W(MAP_W), .REG_W(REG_W), .MAP_DROP(MAP_DROP)) u_t0 (
    .devfn(req_devfn), .reg_off(req_reg), .ofs(t0_ofs), .map(t0_map), .err(t0_err)
  );

  cfg_type1_gen #(.OFS_W(OFS_W), .MAP_W(MAP_W), .BUS_W(BUS_W), .REG_W(REG_W)) u_t1 (
    .bus(req_bus), .devfn(req_devfn), .reg_off(req_reg), .ofs(t1_ofs), .map(t1_map)
  );

  assign kind = (req_bus == '0) ? CYC_TYPE0 : CYC_TYPE1;

  always_comb begin
    if (kind == CYC_TYPE0) begin
      sel_ofs = t0_ofs;
      sel_map = t0_map;
      sel_err = t0_err;
    end else begin
      sel_ofs = t1_ofs;
      sel_map = t1_map;
      sel_err = 1'b0;
    end
  end

  assign pkt_in = {sel_err, sel_map, sel_ofs};

  cfg_out_stage #(.W(PKT_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ready(req_ready), .in_data(pkt_in),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .out_data(pkt_out)
  );

  assign {rsp_err, rsp_map, rsp_ofs} = pkt_out;

  // R9: an accepted request appears on the next cycle
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R4: every result carries the configuration cycle code
  p_cyc_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_map[MAP_ADR_LSB-1:1] == CFG_CYC_CODE);

  // R2 and R3: a good type 0 result has exactly one select bit across offset and map
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_map[0] && !rsp_err |->
      $countones({rsp_ofs[OFS_W-1:SEL_BASE], rsp_map[MAP_W-1:MAP_ADR_LSB]}) == 1);

  // R7: an error result carries no select bit
  p_err_nosel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |->
      !rsp_map[0] && $countones({rsp_ofs[OFS_W-1:SEL_BASE], rsp_map[MAP_W-1:MAP_ADR_LSB]}) == 0);

  // R6: type 1 results never flag an error and keep the map upper bits clear
  p_type1_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_map[0] |-> !rsp_err && rsp_map[MAP_W-1:MAP_ADR_LSB] == '0);
endmodule

// File: tb/sim_pci_cfg_addr_gen.sv
`timescale 1ns/1ps
module sim_pci_cfg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [7:0]  req_devfn = '0;
  logic [7:0]  req_reg = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [23:0] rsp_ofs;
  logic [15:0] rsp_map;
  logic        rsp_err;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pci_cfg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_reg(req_reg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_ofs(rsp_ofs), .rsp_map(rsp_map), .rsp_err(rsp_err)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected result computed from the requirements
  task automatic expect_of(input [7:0] b, input [7:0] d, input [7:0] r,
                           output logic [23:0] eo, output logic [15:0] em, output logic ee);
    int slot;
    slot = int'(d[7:3]);
    ee = 1'b0;
    if (b != 8'd0) begin
      eo = {b, d, r};
      em = 16'h000B;
    end else begin
      eo = {13'd0, d[2:0], r};
      em = 16'h000A;
      if (slot <= 12) eo[slot + 11] = 1'b1;
      else if (slot <= 20) em[slot - 5] = 1'b1;
      else ee = 1'b1;
    end
  endtask

  task automatic xfer(input [7:0] b, input [7:0] d, input [7:0] r);
    logic [23:0] eo; logic [15:0] em; logic ee;
    string tag;
    expect_of(b, d, r, eo, em, ee);
    if (b != 0) tag = "R5/R6";
    else if (d[7:3] <= 12) tag = "R1/R2/R4";
    else if (d[7:3] <= 20) tag = "R1/R3/R4";
    else tag = "R7";
    @(negedge clk);
    req_valid = 1'b1; req_bus = b; req_devfn = d; req_reg = r; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_ofs === eo && rsp_map === em && rsp_err === ee,
          tag, {rsp_valid, 6'd0, rsp_err, 16'd0, rsp_map, rsp_ofs[23:0]},
          {1'b1, 6'd0, ee, 16'd0, em, eo});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] hold_ofs; logic [15:0] hold_map;
    logic [23:0] eo; logic [15:0] em; logic ee;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(rsp_valid === 1'b0, "R9 reset valid", {63'd0, rsp_valid}, 64'd0);
    check(req_ready === 1'b1, "R9 reset ready", {63'd0, req_ready}, 64'd1);

    // Sweep every devfn on bus 0 and on several nonzero buses
    foreach (int_q[i]) ;
    for (int bi = 0; bi < 4; bi++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] b;
        b = (bi == 0) ? 8'h00 : (bi == 1) ? 8'h01 : (bi == 2) ? 8'hA5 : 8'hFF;
        xfer(b, d[7:0], 8'(d * 7 + bi * 61));
      end
    end

    // R8: back-pressure with a second request waiting
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_bus = 8'h00; req_devfn = {5'd16, 3'd2}; req_reg = 8'h3C;
    @(negedge clk);
    expect_of(8'h00, {5'd16, 3'd2}, 8'h3C, eo, em, ee);
    check(rsp_valid === 1'b1 && rsp_map === em && rsp_ofs === eo, "R9 first accept",
          {23'd0, rsp_valid, rsp_map, rsp_ofs}, {23'd0, 1'b1, em, eo});
    hold_ofs = rsp_ofs; hold_map = rsp_map;
    req_bus = 8'h22; req_devfn = 8'h5B; req_reg = 8'h10;
    check(req_ready === 1'b0, "R8 ready low while stalled", {63'd0, req_ready}, 64'd0);
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b1 && rsp_ofs === hold_ofs && rsp_map === hold_map,
          "R8 outputs held", {23'd0, rsp_valid, rsp_map, rsp_ofs}, {23'd0, 1'b1, hold_map, hold_ofs});
    check(req_ready === 1'b0, "R8 ready still low", {63'd0, req_ready}, 64'd0);
    rsp_ready = 1'b1;
    #1;
    check(req_ready === 1'b1, "R9 ready follows rsp_ready", {63'd0, req_ready}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    expect_of(8'h22, 8'h5B, 8'h10, eo, em, ee);
    check(rsp_valid === 1'b1 && rsp_ofs === eo && rsp_map === em && rsp_err === ee,
          "R5 second after drain", {23'd0, rsp_valid, rsp_map, rsp_ofs}, {23'd0, 1'b1, em, eo});
    @(negedge clk);
    check(rsp_valid === 1'b0, "R9 drained", {63'd0, rsp_valid}, 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int int_q[$];
endmodule